// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block turns four reset requests into the reset outputs of a small microcontroller. The requests are a watchdog overflow, an illegal-instruction indication from the CPU decoder, an access to an unmapped address, and a low-voltage detector output. Each request first passes its own configuration enable. A qualified request records its cause in a small status register, pulls the active-low chip reset pin down and holds the CPU in reset. Release then follows a timed two-step sequence counted on the crystal clock. The pin is freed first. The CPU follows a fixed number of cycles later, so that it starts its reset vector fetch on a settled chip.

The power-on reset path, the pin-driven external reset, the analog voltage detector, the watchdog counter and the CPU are not part of this block; they appear only as inputs. `por_n` resets the block itself to the running state with both outputs released, because the power-on path handles its own sequencing. The CPU reads the status register through a single read strobe, and that read empties the register.

The sequencer has four states. RUN: both outputs released. HOLD: a qualified request is present, the pin is low and the CPU is held. PIN_WAIT: the request has ended and the pin stays low while `PIN_HOLD` cycles are counted. CPU_WAIT: the pin is free and the CPU stays held for `CPU_HOLD` cycles. The transitions are:
- RUN→HOLD on any qualified request.
- HOLD→PIN_WAIT when no request remains.
- PIN_WAIT→CPU_WAIT when the count ends.
- CPU_WAIT→RUN when the count ends.
- PIN_WAIT→HOLD and CPU_WAIT→HOLD when a new qualified request arrives (restart).

Top module: `rst_cause_seq`

## Requirements
- R1: A watchdog overflow is a qualified request only when `cfg_wdog_off` is 0; it sets status bit 3.
- R2: `illegal_op` is always a qualified request. `stop_op` counts as one only when `cfg_stop_ok` is 0. Either sets status bit 2.
- R3: `unmapped_acc` is a qualified request only while `opcode_fetch` is 1, and then it sets status bit 1. A data access (`opcode_fetch` 0) changes neither the outputs nor the status.
- R4: `low_volt` is a qualified request only when `cfg_lv_pwrdn` and `cfg_lv_rst_off` are both 0; it sets status bit 0.
- R5: `rst_pin_n` is low while any qualified request is present. It stays low for `PIN_HOLD` (4096) clock cycles after the last request ends.
- R6: `cpu_rst` is released `CPU_HOLD` (64) clock cycles after `rst_pin_n` rises. `cpu_rst` is never 0 while `rst_pin_n` is 0.
- R7: A qualified request during either countdown drives the pin low again and restarts the full sequence from zero.
- R8: A qualified request clears every status bit and then sets exactly the bits of the causes present in that cycle. Several simultaneous causes all get set.
- R9: `stat_rdata` shows the status register. A cycle with `stat_rd` high and no new request clears it to 0.
- R10: Inputs are sampled on `xclk` and the outputs come from registers. A request sampled at edge k drives the pin low and sets the status at edge k+1. With a one-cycle request, the pin rises at edge k+2+PIN_HOLD.
- R11: After `por_n` is released, `rst_pin_n` is 1, `cpu_rst` is 0 and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xclk | input | 1 | Crystal clock |
| por_n | input | 1 | Active-low asynchronous block reset |
| wdog_ovf | input | 1 | Watchdog counter overflow |
| illegal_op | input | 1 | Illegal instruction decoded |
| stop_op | input | 1 | STOP instruction decoded |
| unmapped_acc | input | 1 | Access to an unmapped address |
| opcode_fetch | input | 1 | Current access is an opcode fetch |
| low_volt | input | 1 | Low-voltage detector output |
| cfg_wdog_off | input | 1 | Watchdog reset disable |
| cfg_stop_ok | input | 1 | Stop mode permitted |
| cfg_lv_pwrdn | input | 1 | Low-voltage detector powered down |
| cfg_lv_rst_off | input | 1 | Low-voltage reset disable |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| stat_rdata | output | 4 | Status: bit3 watchdog, bit2 illegal opcode, bit1 illegal address, bit0 low voltage |
| rst_pin_n | output | 1 | Active-low chip reset pin drive |
| cpu_rst | output | 1 | CPU reset, active high |

## Verification
A request sampled at edge k shows on the pin and in the status after edge k+1, one register of input sampling plus one of state and outputs. The bench therefore checks one cycle after the sample edge, and also checks at the sample edge itself that nothing has moved yet. The pin release is due at edge k+2+4096 and the CPU release 64 edges later. The bench counts rising edges and compares at falling edges one cycle on each side of those boundaries. A read clears the status at the edge that ends the read cycle, and the bench checks it at the next falling edge. Requests that do not qualify are checked by confirming, a few cycles later, that the outputs and the status are unchanged.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int unsigned NCAUSE  = 4;
    localparam int unsigned IDX_LV  = 0;
    localparam int unsigned IDX_AD  = 1;
    localparam int unsigned IDX_OP  = 2;
    localparam int unsigned IDX_WD  = 3;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD     = 2'd1,
        ST_PIN_WAIT = 2'd2,
        ST_CPU_WAIT = 2'd3
    } rsc_state_e;

    typedef struct packed {
        logic wdog;
        logic ill_op;
        logic stop_op;
        logic unmapped;
        logic fetch;
        logic low_volt;
        logic wdog_off;
        logic stop_ok;
        logic lv_pwrdn;
        logic lv_rst_off;
    } rsc_req_t;
endpackage

// File: rtl/rsc_req_qual.sv
module rsc_req_qual
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rsc_req_t          req_in,
    output logic [NCAUSE-1:0] trig
);
    rsc_req_t req_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s <= '0;
        end else begin
            req_s <= req_in;
        end
    end

    always_comb begin
        trig         = '0;
        trig[IDX_WD] = req_s.wdog & ~req_s.wdog_off;
        trig[IDX_OP] = req_s.ill_op | (req_s.stop_op & ~req_s.stop_ok);
        trig[IDX_AD] = req_s.unmapped & req_s.fetch;
        trig[IDX_LV] = req_s.low_volt & ~req_s.lv_pwrdn & ~req_s.lv_rst_off;
    end
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] trig,
    input  logic              rd,
    output logic [NCAUSE-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (|trig) begin
            status <= trig;
        end else if (rd) begin
            status <= '0;
        end
    end
endmodule

// File: rtl/rsc_release_fsm.sv
module rsc_release_fsm
    import rsc_pkg::*;
#(
    parameter int unsigned PIN_HOLD = 4096,
    parameter int unsigned CPU_HOLD = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_req,
    output rsc_state_e state,
    output logic       pin_n,
    output logic       cpu_rst
);
    localparam int unsigned MAXH = (PIN_HOLD > CPU_HOLD) ? PIN_HOLD : CPU_HOLD;
    localparam int unsigned CW   = $clog2(MAXH + 1);
    localparam logic [CW-1:0] PIN_LAST = CW'(PIN_HOLD - 1);
    localparam logic [CW-1:0] CPU_LAST = CW'(CPU_HOLD - 1);

    rsc_state_e state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (any_req) state_nx = ST_HOLD;
            ST_HOLD:     if (!any_req) state_nx = ST_PIN_WAIT;
            ST_PIN_WAIT: begin
                if (any_req)              state_nx = ST_HOLD;
                else if (cnt == PIN_LAST) state_nx = ST_CPU_WAIT;
            end
            ST_CPU_WAIT: begin
                if (any_req)              state_nx = ST_HOLD;
                else if (cnt == CPU_LAST) state_nx = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || state_nx == ST_HOLD || state_nx == ST_RUN) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_n   <= 1'b1;
            cpu_rst <= 1'b0;
        end else begin
            pin_n   <= !(state_nx == ST_HOLD || state_nx == ST_PIN_WAIT);
            cpu_rst <= (state_nx != ST_RUN);
        end
    end
endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
    import rsc_pkg::*;
#(
    parameter int unsigned PIN_HOLD = 4096,
    parameter int unsigned CPU_HOLD = 64
) (
    input  logic              xclk,
    input  logic              por_n,
    input  logic              wdog_ovf,
    input  logic              illegal_op,
    input  logic              stop_op,
    input  logic              unmapped_acc,
    input  logic              opcode_fetch,
    input  logic              low_volt,
    input  logic              cfg_wdog_off,
    input  logic              cfg_stop_ok,
    input  logic              cfg_lv_pwrdn,
    input  logic              cfg_lv_rst_off,
    input  logic              stat_rd,
    output logic [NCAUSE-1:0] stat_rdata,
    output logic              rst_pin_n,
    output logic              cpu_rst
);
    rsc_req_t          req_bundle;
    logic [NCAUSE-1:0] trig;
    logic [NCAUSE-1:0] status;
    rsc_state_e        state;

    always_comb begin
        req_bundle.wdog       = wdog_ovf;
        req_bundle.ill_op     = illegal_op;
        req_bundle.stop_op    = stop_op;
        req_bundle.unmapped   = unmapped_acc;
        req_bundle.fetch      = opcode_fetch;
        req_bundle.low_volt   = low_volt;
        req_bundle.wdog_off   = cfg_wdog_off;
        req_bundle.stop_ok    = cfg_stop_ok;
        req_bundle.lv_pwrdn   = cfg_lv_pwrdn;
        req_bundle.lv_rst_off = cfg_lv_rst_off;
    end

    rsc_req_qual u_qual (
        .clk    (xclk),
        .rst_n  (por_n),
        .req_in (req_bundle),
        .trig   (trig)
    );

    rsc_status_reg u_stat (
        .clk    (xclk),
        .rst_n  (por_n),
        .trig   (trig),
        .rd     (stat_rd),
        .status (status)
    );

    rsc_release_fsm #(
        .PIN_HOLD (PIN_HOLD),
        .CPU_HOLD (CPU_HOLD)
    ) u_fsm (
        .clk     (xclk),
        .rst_n   (por_n),
        .any_req (|trig),
        .state   (state),
        .pin_n   (rst_pin_n),
        .cpu_rst (cpu_rst)
    );

    assign stat_rdata = status;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
    import rsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NCAUSE-1:0] trig,
    input logic [NCAUSE-1:0] status,
    input logic              rd,
    input logic              pin_n,
    input logic              cpu_rst,
    input logic              wdog_ovf,
    input logic              cfg_wdog_off,
    input logic              unmapped_acc,
    input logic              opcode_fetch
);
    // R5: a qualified request drives both resets at the next edge
    a_r5_hold_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |=> (!pin_n && cpu_rst));

    // R6: the CPU is never released while the pin is low
    a_r6_cpu_after_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_n) |-> cpu_rst);

    // R6: the pin rising leaves the CPU still held
    a_r6_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_n) |-> cpu_rst);

    // R8: the status takes exactly the causes of the request cycle
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |=> (status == $past(trig)));

    // R9: a read with no new request empties the status
    a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(|trig)) |=> (status == '0));

    // R1: the watchdog bit only appears after an enabled overflow
    a_r1_wdog_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[IDX_WD]) |-> ($past(wdog_ovf, 2) && !$past(cfg_wdog_off, 2)));

    // R3: the illegal-address bit only appears after an opcode fetch
    a_r3_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[IDX_AD]) |-> ($past(unmapped_acc, 2) && $past(opcode_fetch, 2)));
endmodule

bind rst_cause_seq rsc_checker u_chk (
    .clk          (xclk),
    .rst_n        (por_n),
    .trig         (trig),
    .status       (status),
    .rd           (stat_rd),
    .pin_n        (rst_pin_n),
    .cpu_rst      (cpu_rst),
    .wdog_ovf     (wdog_ovf),
    .cfg_wdog_off (cfg_wdog_off),
    .unmapped_acc (unmapped_acc),
    .opcode_fetch (opcode_fetch)
);

// File: tb/rst_cause_seq_test.sv
`timescale 1ns/1ps
module rst_cause_seq_test;
    localparam int PH = 4096;
    localparam int CH = 64;

    logic xclk = 1'b0;
    logic por_n = 1'b0;
    logic wdog_ovf = 0, illegal_op = 0, stop_op = 0, unmapped_acc = 0;
    logic opcode_fetch = 0, low_volt = 0;
    logic cfg_wdog_off = 0, cfg_stop_ok = 0, cfg_lv_pwrdn = 0, cfg_lv_rst_off = 0;
    logic stat_rd = 0;
    logic [3:0] stat_rdata;
    logic rst_pin_n, cpu_rst;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 xclk = ~xclk;
    always @(posedge xclk) cyc <= cyc + 1;

    rst_cause_seq uut (
        .xclk(xclk), .por_n(por_n), .wdog_ovf(wdog_ovf), .illegal_op(illegal_op),
        .stop_op(stop_op), .unmapped_acc(unmapped_acc), .opcode_fetch(opcode_fetch),
        .low_volt(low_volt), .cfg_wdog_off(cfg_wdog_off), .cfg_stop_ok(cfg_stop_ok),
        .cfg_lv_pwrdn(cfg_lv_pwrdn), .cfg_lv_rst_off(cfg_lv_rst_off), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .rst_pin_n(rst_pin_n), .cpu_rst(cpu_rst)
    );

    function automatic logic [3:0] exp_cause(logic wd, logic op, logic st, logic un,
                                             logic fe, logic lv, logic [3:0] cfg);
        logic [3:0] e;
        e[3] = wd & ~cfg[3];
        e[2] = op | (st & ~cfg[2]);
        e[1] = un & fe;
        e[0] = lv & ~cfg[1] & ~cfg[0];
        return e;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_neg(int c);
        while (cyc < c) @(negedge xclk);
    endtask

    task automatic set_cfg(logic [3:0] cfg);
        cfg_wdog_off   = cfg[3];
        cfg_stop_ok    = cfg[2];
        cfg_lv_pwrdn   = cfg[1];
        cfg_lv_rst_off = cfg[0];
    endtask

    // one-cycle request; returns the sample edge number
    task automatic pulse(logic [5:0] r, output int base);
        {wdog_ovf, illegal_op, stop_op, unmapped_acc, opcode_fetch, low_volt} = r;
        @(negedge xclk);
        {wdog_ovf, illegal_op, stop_op, unmapped_acc, opcode_fetch, low_volt} = '0;
        base = cyc;
    endtask

    task automatic read_clear(logic [3:0] expv);
        stat_rd = 1'b1;
        chk("R9 read data", stat_rdata, expv);
        @(negedge xclk);
        stat_rd = 1'b0;
        chk("R9 cleared by read", stat_rdata, 0);
    endtask

    task automatic full_seq(int base, logic [3:0] expv, bit from_run);
        if (from_run) chk("R10 no change at sample edge", rst_pin_n, 1);
        wait_neg(base + 1);
        chk("R5 pin low after request", rst_pin_n, 0);
        chk("R5 cpu held", cpu_rst, 1);
        chk("R8 status capture", stat_rdata, expv);
        wait_neg(base + 1 + PH);
        chk("R5 pin still low at end of count", rst_pin_n, 0);
        wait_neg(base + 2 + PH);
        chk("R10 pin released on time", rst_pin_n, 1);
        chk("R6 cpu held after pin", cpu_rst, 1);
        wait_neg(base + 1 + PH + CH);
        chk("R6 cpu still held", cpu_rst, 1);
        wait_neg(base + 2 + PH + CH);
        chk("R6 cpu released", cpu_rst, 0);
        read_clear(expv);
    endtask

    task automatic no_reset(int base);
        wait_neg(base + 3);
        chk("no reset pin", rst_pin_n, 1);
        chk("no reset cpu", cpu_rst, 0);
        chk("status untouched", stat_rdata, 0);
    endtask

    initial begin
        int base;
        logic [3:0] cfg;
        logic [5:0] r;
        logic [3:0] e;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge xclk);
        por_n = 1'b1;
        @(negedge xclk);
        chk("R11 pin after reset", rst_pin_n, 1);
        chk("R11 cpu after reset", cpu_rst, 0);
        chk("R11 status after reset", stat_rdata, 0);

        // R1: watchdog disabled, then enabled
        set_cfg(4'b1000); pulse(6'b100000, base); no_reset(base);
        set_cfg(4'b0000); pulse(6'b100000, base); full_seq(base, 4'b1000, 1);
        // R2: STOP with stop permitted is harmless; with stop barred it resets
        set_cfg(4'b0100); pulse(6'b001000, base); no_reset(base);
        set_cfg(4'b0000); pulse(6'b001000, base); full_seq(base, 4'b0100, 1);
        // R3: data access to unmapped address ignored
        pulse(6'b000100, base); no_reset(base);
        // R4: each low-voltage gate blocks
        set_cfg(4'b0010); pulse(6'b000001, base); no_reset(base);
        set_cfg(4'b0001); pulse(6'b000001, base); no_reset(base);
        // R4/R5: held low-voltage request, count starts after recovery
        set_cfg(4'b0000);
        low_volt = 1'b1;
        repeat (300) @(negedge xclk);
        chk("R4 pin low during low voltage", rst_pin_n, 0);
        low_volt = 1'b0;
        base = cyc;
        full_seq(base, 4'b0001, 0);
        // R8: all causes together
        pulse(6'b111111, base); full_seq(base, 4'b1111, 1);
        // R7: restart in PIN_WAIT with a different cause
        pulse(6'b100000, base);
        wait_neg(base + 2000);
        pulse(6'b000001, base);
        chk("R7 pin low on restart", rst_pin_n, 0);
        full_seq(base, 4'b0001, 0);
        // R7: restart in CPU_WAIT
        pulse(6'b010000, base);
        wait_neg(base + PH + 20);
        chk("R7 in cpu wait pin free", rst_pin_n, 1);
        pulse(6'b000110, base);
        full_seq(base, 4'b0010, 0);
        // random rounds
        for (int i = 0; i < 12; i++) begin
            cfg = 4'($urandom);
            r   = 6'($urandom) & 6'($urandom);
            set_cfg(cfg);
            e = exp_cause(r[5], r[4], r[3], r[2], r[1], r[0], cfg);
            pulse(r, base);
            if (e != 0) full_seq(base, e, 1);
            else no_reset(base);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 180000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, 180000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule